// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request lines and resolves them into one interrupt line for the processor. It has a request register, an in-service register and a mask register. Priority is either fixed, with line 0 highest, or rotating, where the level most recently finished drops to the bottom. The processor answers `irq` with two acknowledge strobes. The first strobe returns a programmable vector byte for the winning line and marks that line in service. Depending on the mode, the in-service bit is cleared by the second strobe or by a later end-of-interrupt command.

Software programs the block over a small strobe bus with one address bit. A setup word on address 0 with bit 4 set starts the setup sequence. Three further setup words on address 1 follow it: the vector base, the per-line sensing select and the mode byte. After setup, a write to address 1 loads the mask. Writes to address 0 with bit 4 clear are commands: end-of-interrupt, status-read select and poll. In poll mode the request line to the processor stays low. Software then reads a poll byte to find and claim the highest pending line.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq` is low. A setup word (address 0, bit 4 = 1; bit 2 = 1 selects vector step 4, else 8) does the following: clears the mask and in-service registers, makes line 7 the lowest priority, and makes an address-0 read return the request register. It also re-arms edge sensing, so a line that is already high raises nothing until it goes low and then high again.
- R2: A line whose bit in the sensing word (third setup word) is 0 is edge sensed: only a low-to-high change sets its request bit, and a high-to-low change leaves the bit set. A line with its bit at 1 is level sensed: its request bit follows the line.
- R3: A line whose mask bit (address-1 write after setup) is 1 neither raises `irq` nor wins a poll.
- R4: With fixed priority, the lowest-numbered unmasked pending line wins. After the first acknowledge strobe, `ack_vector` equals base + level × step (8-bit wrap).
- R5: With mode bit 0 (auto end) set, the winner's in-service bit is set by the first strobe and cleared by the second. With mode bit 0 clear, the bit stays set after the second strobe.
- R6: A command write to address 0 with bits 4:3 = 00 and bit 5 = 1 ends an interrupt. If bit 6 = 0, it clears the highest-priority in-service bit. If bit 6 = 1, it clears the level given in bits 2:0.
- R7: With mode bit 3 (rotating) set, the level cleared by an end-of-interrupt becomes the lowest priority. The line after it becomes the highest.
- R8: With mode bit 1 (nesting) set, a pending line raises `irq` while others are in service only if it outranks every in-service level. With mode bit 1 clear, `irq` stays low while any in-service bit is set.
- R9: With mode bit 2 (poll) set, `irq` stays low while requests still latch. A command write with bits 4:3 = 01 and bit 2 = 1 makes the next address-0 read a poll byte: bit 7 = request present, bits 2:0 = winning level. That read claims the winner and sets its in-service bit.
- R10: A command write with bits 4:3 = 01 and bit 1 = 1 selects what address-0 reads return: the in-service register if bit 0 = 1, the request register if bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 8 | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_a0 | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse |
| ack_vector | output | 8 | Vector byte latched by the first acknowledge |
| irq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle the checker confirms several rules. Poll mode and non-nested mode with work in service hold `irq` low. `irq` never rises without an unmasked pending request. A first acknowledge always marks its winner in service. An auto-ended second acknowledge clears that mark. A setup word leaves the mask and in-service registers empty. The bench scenarios cover the rest: vector arithmetic for both step sizes, priority order after rotation, edge versus level sensing, the re-arm of held lines after setup, and the contents of poll and status reads. All of these depend on sequences of bus writes and line changes.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_SENSE, ST_MODE, ST_RUN
  } setup_st_e;

  // mode byte bit positions
  localparam int MB_AUTO = 0;
  localparam int MB_NEST = 1;
  localparam int MB_POLL = 2;
  localparam int MB_ROT  = 3;

  function automatic logic [7:0] vec_calc(input logic [7:0] base,
                                          input logic [7:0] lvl,
                                          input logic step4);
    return base + (step4 ? (lvl << 2) : (lvl << 3));
  endfunction
endpackage

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N   = 8,
  parameter int LW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] lowest,
  output logic          found,
  output logic [LW-1:0] level
);
  // scan from lowest priority up, so the last hit is the highest
  always_comb begin
    found = 1'b0;
    level = '0;
    for (int i = N; i >= 1; i--) begin
      int idx;
      idx = (int'(lowest) + i) % N;
      if (req[idx]) begin
        found = 1'b1;
        level = LW'(idx);
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ir,
  input  logic [N-1:0] level_sel,
  input  logic         rearm,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;
  logic [N-1:0] rise;

  assign rise = ir & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else if (rearm) prev <= '1;
    else prev <= ir;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irr[g] <= 1'b0;
      else if (rearm) irr[g] <= 1'b0;
      else if (level_sel[g]) irr[g] <= ir[g] & ~clr[g];
      else irr[g] <= (irr[g] | rise[g]) & ~clr[g];
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl import pic_pkg::*; #(
  parameter int NUM_IR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IR-1:0] ir,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_a0,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ack,
  output logic [7:0]        ack_vector,
  output logic              irq
);
  localparam int LVL_W = $clog2(NUM_IR);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_IR - 1);

  setup_st_e         st;
  logic [7:0]        vec_base;
  logic              step4, aeoi, nest_en, poll_mode, rot_mode;
  logic              rd_isr, poll_pend, ack_phase, ack_had;
  logic [NUM_IR-1:0] imr, isr, irr, lvl_sel;
  logic [LVL_W-1:0]  low_prio, ack_lvl_q;
  logic [7:0]        ack_vec_q;

  // named events, also used by the checker
  logic running, icw1_evt, ocw2_evt, ocw3_evt, setup_wr, imr_wr;
  logic ack1_evt, ack2_evt, poll_rd_evt, poll_ack, eoi_evt, eoi_valid;
  logic cand_found, svc_found;
  logic [LVL_W-1:0]  cand_lvl, svc_lvl, eoi_lvl;
  logic [NUM_IR-1:0] cand_oh, ack_oh, eoi_oh, irr_clr, isr_set, isr_clr;

  function automatic logic [LVL_W-1:0] prio_rank(input logic [LVL_W-1:0] lvl,
                                                 input logic [LVL_W-1:0] low);
    return lvl - low - LVL_W'(1);
  endfunction

  assign running     = (st == ST_RUN);
  assign icw1_evt    = bus_wr & ~bus_a0 & bus_wdata[4];
  assign ocw2_evt    = bus_wr & ~bus_a0 & ~bus_wdata[4] & ~bus_wdata[3] & running;
  assign ocw3_evt    = bus_wr & ~bus_a0 & ~bus_wdata[4] &  bus_wdata[3] & running;
  assign setup_wr    = bus_wr & bus_a0 & ~running;
  assign imr_wr      = bus_wr & bus_a0 & running;
  assign ack1_evt    = ack & running & ~ack_phase;
  assign ack2_evt    = ack & running &  ack_phase;
  assign poll_rd_evt = bus_rd & ~bus_a0 & poll_pend & running;
  assign poll_ack    = poll_rd_evt & cand_found;

  pic_req_latch #(.N(NUM_IR)) u_latch (
    .clk(clk), .rst_n(rst_n), .ir(ir), .level_sel(lvl_sel),
    .rearm(icw1_evt), .clr(irr_clr), .irr(irr)
  );

  pic_prio_resolve #(.N(NUM_IR), .LW(LVL_W)) u_cand (
    .req(irr & ~imr), .lowest(low_prio), .found(cand_found), .level(cand_lvl)
  );

  pic_prio_resolve #(.N(NUM_IR), .LW(LVL_W)) u_svc (
    .req(isr), .lowest(low_prio), .found(svc_found), .level(svc_lvl)
  );

  assign cand_oh   = cand_found ? (NUM_IR'(1) << cand_lvl) : '0;
  assign ack_oh    = NUM_IR'(1) << ack_lvl_q;
  assign eoi_evt   = ocw2_evt & bus_wdata[5];
  assign eoi_lvl   = bus_wdata[6] ? bus_wdata[LVL_W-1:0] : svc_lvl;
  assign eoi_valid = eoi_evt & (bus_wdata[6] | svc_found);
  assign eoi_oh    = NUM_IR'(1) << eoi_lvl;

  assign irr_clr = (ack1_evt | poll_ack) ? cand_oh : '0;
  assign isr_set = (ack1_evt | (poll_ack & ~aeoi)) ? cand_oh : '0;
  assign isr_clr = ((ack2_evt & aeoi & ack_had) ? ack_oh : '0)
                 | (eoi_valid ? eoi_oh : '0);

  always_comb begin
    irq = 1'b0;
    if (running && !poll_mode && cand_found) begin
      if (isr == '0) irq = 1'b1;
      else if (nest_en && svc_found)
        irq = prio_rank(cand_lvl, low_prio) < prio_rank(svc_lvl, low_prio);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_a0) bus_rdata = 8'(imr);
    else if (poll_pend) begin
      bus_rdata[LVL_W-1:0] = cand_lvl;
      bus_rdata[7]         = cand_found;
    end
    else bus_rdata = rd_isr ? 8'(isr) : 8'(irr);
  end

  assign ack_vector = ack_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else if (icw1_evt) isr <= '0;
    else isr <= (isr | isr_set) & ~isr_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      vec_base <= '0;  step4 <= 1'b0;  lvl_sel <= '0;  imr <= '0;
      aeoi <= 1'b0;  nest_en <= 1'b0;  poll_mode <= 1'b0;  rot_mode <= 1'b0;
      rd_isr <= 1'b0;  poll_pend <= 1'b0;  ack_phase <= 1'b0;  ack_had <= 1'b0;
      low_prio <= LVL_LAST;  ack_lvl_q <= LVL_LAST;  ack_vec_q <= '0;
    end else if (icw1_evt) begin
      st <= ST_BASE;
      step4 <= bus_wdata[2];
      imr <= '0;  rd_isr <= 1'b0;  poll_pend <= 1'b0;  ack_phase <= 1'b0;
      low_prio <= LVL_LAST;
    end else begin
      if (setup_wr) begin
        case (st)
          ST_BASE:  begin vec_base <= bus_wdata;  st <= ST_SENSE; end
          ST_SENSE: begin lvl_sel <= bus_wdata[NUM_IR-1:0];  st <= ST_MODE; end
          ST_MODE: begin
            aeoi      <= bus_wdata[MB_AUTO];
            nest_en   <= bus_wdata[MB_NEST];
            poll_mode <= bus_wdata[MB_POLL];
            rot_mode  <= bus_wdata[MB_ROT];
            st        <= ST_RUN;
          end
          default: st <= st;
        endcase
      end
      if (imr_wr) imr <= bus_wdata[NUM_IR-1:0];
      if (ocw3_evt) begin
        if (bus_wdata[1]) rd_isr <= bus_wdata[0];
        poll_pend <= bus_wdata[2];
      end else if (poll_rd_evt) poll_pend <= 1'b0;
      if (ack1_evt) begin
        ack_phase <= 1'b1;
        ack_had   <= cand_found;
        ack_lvl_q <= cand_found ? cand_lvl : LVL_LAST;
        ack_vec_q <= vec_calc(vec_base, 8'(cand_found ? cand_lvl : LVL_LAST), step4);
      end
      if (ack2_evt) begin
        ack_phase <= 1'b0;
        if (rot_mode && aeoi && ack_had) low_prio <= ack_lvl_q;
      end
      if (eoi_valid && rot_mode) low_prio <= eoi_lvl;
    end
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [N-1:0] imr,
  input logic [N-1:0] isr,
  input logic [N-1:0] irr,
  input logic         nest_en,
  input logic         poll_mode,
  input logic         aeoi,
  input logic         icw1_evt,
  input logic         ack1_evt,
  input logic         ack2_evt,
  input logic         cand_found,
  input logic [N-1:0] cand_oh,
  input logic [N-1:0] ack_oh
);
  // R9: poll mode never drives the processor line
  a_r9_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    poll_mode |-> !irq);

  // R8: without nesting, nothing is raised while work is in service
  a_r8_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && isr != '0) |-> !irq);

  // R3: irq needs an unmasked pending request
  a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irr & ~imr) != '0));

  // R5: first acknowledge marks the winner in service
  a_r5_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1_evt && cand_found && !icw1_evt) |=> ((isr & $past(cand_oh)) != '0));

  // R5: auto end clears the mark on the second acknowledge
  a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack2_evt && aeoi && !icw1_evt) |=> ((isr & $past(ack_oh)) == '0));

  // R1: setup word empties mask and in-service registers
  a_r1_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_evt |=> (imr == '0 && isr == '0));
endmodule

bind pic_ctrl pic_checker #(.N(NUM_IR)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .imr(imr), .isr(isr), .irr(irr),
  .nest_en(nest_en), .poll_mode(poll_mode), .aeoi(aeoi),
  .icw1_evt(icw1_evt), .ack1_evt(ack1_evt), .ack2_evt(ack2_evt),
  .cand_found(cand_found), .cand_oh(cand_oh), .ack_oh(ack_oh)
);

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0, ack = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, ack_vector;
  logic       irq;
  int tests = 0, fails = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  pic_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .ack_vector(ack_vector), .irq(irq)
  );

  function automatic logic [7:0] exp_vec(input logic [7:0] base, input int lvl,
                                         input bit step4);
    return base + 8'(lvl * (step4 ? 4 : 8));
  endfunction

  function automatic int exp_top(input logic [7:0] pend, input int low);
    for (int k = 1; k <= 8; k++) begin
      if (pend[(low + k) % 8]) return (low + k) % 8;
    end
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    bus_wr = 1'b1; bus_a0 = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    bus_rd = 1'b1; bus_a0 = a;
    #1 d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic setup(input bit step4, input logic [7:0] base,
                       input logic [7:0] sense, input logic [7:0] mode);
    wr(1'b0, 8'h10 | (step4 ? 8'h04 : 8'h00));
    wr(1'b1, base);
    wr(1'b1, sense);
    wr(1'b1, mode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    // fixed priority, software end, no nesting
    setup(1'b0, 8'h40, 8'h00, 8'h00);
    rd(1'b1, rv); chk("R1 mask cleared", rv, 8'h00);
    rd(1'b0, rv); chk("R1 read gives requests", rv, 8'h00);
    ir[3] = 1'b1; tick();
    rd(1'b0, rv); chk("R2 rising edge latched", rv, 8'h08);
    ir[3] = 1'b0; tick();
    rd(1'b0, rv); chk("R2 falling edge ignored", rv, 8'h08);
    ir[5] = 1'b1; tick();
    chk("R4 irq raised", {7'd0, irq}, 8'h01);
    pulse(); chk("R4 vector line3", ack_vector, exp_vec(8'h40, 3, 1'b0));
    pulse();
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R5 kept in service / R10 isr", rv, 8'h08);
    chk("R8 no nest while serviced", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, rv); chk("R6 nonspecific end", rv, 8'h00);
    chk("R8 irq back after end", {7'd0, irq}, 8'h01);
    pulse(); chk("R4 vector line5", ack_vector, exp_vec(8'h40, 5, 1'b0));
    pulse();
    wr(1'b0, 8'h65);
    rd(1'b0, rv); chk("R6 specific end", rv, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, rv); chk("R10 irr select", rv, 8'h00);

    // mask
    wr(1'b1, 8'h04);
    ir[2] = 1'b1; tick();
    chk("R3 masked no irq", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, rv); chk("R3 masked not polled", rv, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, rv); chk("R9 poll byte", rv, 8'h82);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R9 poll claims", rv, 8'h04);
    ir = '0; tick();

    // held line through setup needs a fresh edge
    ir[1] = 1'b1; tick();
    setup(1'b0, 8'h40, 8'h00, 8'h00);
    tick();
    chk("R1 held line no irq", {7'd0, irq}, 8'h00);
    rd(1'b0, rv); chk("R1 edge rearmed", rv, 8'h00);
    ir[1] = 1'b0; tick(); ir[1] = 1'b1; tick();
    chk("R1 fresh edge irq", {7'd0, irq}, 8'h01);
    ir = '0; tick();

    // level sensing on line 0
    setup(1'b0, 8'h40, 8'h01, 8'h00);
    ir[0] = 1'b1; tick();
    rd(1'b0, rv); chk("R2 level follows high", rv, 8'h01);
    ir[0] = 1'b0; tick();
    rd(1'b0, rv); chk("R2 level follows low", rv, 8'h00);

    // auto end, step 4
    setup(1'b1, 8'h80, 8'h00, 8'h01);
    ir[6] = 1'b1; tick();
    pulse(); chk("R4 step4 vector", ack_vector, exp_vec(8'h80, 6, 1'b1));
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R5 set by first ack", rv, 8'h40);
    pulse(); rd(1'b0, rv); chk("R5 cleared by second ack", rv, 8'h00);
    ir = '0; tick();

    // nesting
    setup(1'b0, 8'h40, 8'h00, 8'h02);
    ir[4] = 1'b1; tick(); pulse(); pulse();
    ir[6] = 1'b1; tick();
    chk("R8 lower blocked", {7'd0, irq}, 8'h00);
    ir[1] = 1'b1; tick();
    chk("R8 higher nests", {7'd0, irq}, 8'h01);
    pulse(); chk("R8 nested vector", ack_vector, exp_vec(8'h40, 1, 1'b0));
    pulse();
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R6 clears highest only", rv, 8'h10);
    chk("R8 line6 still blocked", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R8 line6 after end", {7'd0, irq}, 8'h01);
    ir = '0; tick();

    // rotating
    setup(1'b0, 8'h40, 8'h00, 8'h08);
    ir[2] = 1'b1; tick(); pulse(); pulse(); wr(1'b0, 8'h20);
    ir[1] = 1'b1; ir[3] = 1'b1; tick();
    pulse(); chk("R7 rotated winner", ack_vector, exp_vec(8'h40, exp_top(8'h0A, 2), 1'b0));
    pulse(); wr(1'b0, 8'h20);
    pulse(); chk("R7 second rotation", ack_vector, exp_vec(8'h40, exp_top(8'h02, 3), 1'b0));
    pulse(); wr(1'b0, 8'h20);
    ir = '0; tick();

    // poll mode
    setup(1'b0, 8'h40, 8'h00, 8'h04);
    ir[0] = 1'b1; tick();
    chk("R9 poll mode no irq", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, rv); chk("R9 poll present", rv, 8'h80);
    wr(1'b0, 8'h0B); rd(1'b0, rv); chk("R9 poll sets isr", rv, 8'h01);
    ir = '0; tick();

    // random fixed-priority pairs
    void'($urandom(32'h5eed));
    for (int it = 0; it < 24; it++) begin
      logic [7:0] base, pend;
      bit s4;
      int a, b;
      base = 8'($urandom);
      s4   = 1'($urandom);
      a    = int'($urandom % 8);
      b    = int'($urandom % 8);
      pend = 8'(1 << a) | 8'(1 << b);
      ir = '0; tick();
      setup(s4, base, 8'h00, 8'h00);
      ir = pend; tick();
      pulse();
      chk("R4 random vector", ack_vector, exp_vec(base, exp_top(pend, 7), s4));
      pulse();
    end
    ir = '0; tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule